// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error-Tagged Queue

This block turns an asynchronous serial line into characters and queues them. It runs from the system clock. A separate enable tick arrives at sixteen times the bit rate. When the line falls while the receiver is idle, the receiver waits half a bit and checks the line again, so a short low glitch is thrown away. It then samples each data bit, the optional parity bit and the first stop bit at the centre of the bit. Character width (7 or 8 bits) and parity (none, even or odd) come from static configuration inputs. The receiver latches these inputs at the start of each character.

Every finished character becomes one 10-bit queue entry. The entry holds the data together with two flags that belong to that character alone: a bad-parity flag and a bad-stop-bit flag. A reader sees the oldest entry and the fill level, and removes the entry with a one-cycle pop strobe. Four event outputs go to an interrupt controller: a level for almost full, a level for full, a pulse when a character arrives with no room for it, and a pulse when data has been sitting in the queue with a quiet line for several character times.

Top module: `serial_rx_fifo`

## Requirements
- R1: After synchronous reset the level is 0 and almost-full, full, overrun and timeout are all 0.
- R2: An 8-bit character is received LSB first. Its entry carries the data in bits [7:0], and bit 8 (parity error) and bit 9 (frame error) are 0 when the framing is correct.
- R3: A falling edge starts a character only if the line is still low 8 ticks later, at mid-bit. A shorter low pulse leaves the queue unchanged.
- R4: With `cfg_eight_bits` = 0, seven data bits are received and bit 7 of the stored entry is 0.
- R5: With `cfg_par_en` = 1, one parity bit follows the data. `cfg_par_odd` = 0 selects even parity and 1 selects odd parity. Bit 8 of the entry is 1 exactly when the parity received does not match.
- R6: Bit 9 of the entry is 1 when the first stop bit is sampled low. The data is still stored.
- R7: Entries are read oldest first. `rd_entry` shows the oldest entry whenever the level is above 0, and a pop removes it. A pop while the queue is empty changes nothing.
- R8: `ev_almost_full` is high exactly when the level is 12 or more. `ev_full` is high exactly when the level is 16.
- R9: A character that completes while 16 entries are held raises `ev_overrun` for one cycle and is dropped. The stored entries and the level stay as they were.
- R10: `ev_timeout` pulses once after the queue has been non-empty for four character times of ticks with no character in progress. One character time is 16 × (start + data + parity + one stop) ticks. No pulse occurs while the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Sampling enable, pulsed at 16× the bit rate |
| rxd | input | 1 | Serial line, idles high |
| cfg_eight_bits | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | 1: a parity bit follows the data |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| rd_pop | input | 1 | Removes the oldest entry |
| rd_entry | output | 10 | Oldest entry: {frame error, parity error, data[7:0]} |
| rd_level | output | 5 | Number of entries held |
| ev_almost_full | output | 1 | Level is at least 12 |
| ev_full | output | 1 | Level is 16 |
| ev_overrun | output | 1 | One-cycle pulse: character dropped because the queue was full |
| ev_timeout | output | 1 | One-cycle pulse: data left waiting on an idle line |

## Verification
The main data path is driven with alternating-bit and sparse patterns in 8-bit mode and an all-ones pattern in 7-bit mode. The alternating and sparse patterns expose bit-order and bit-position faults. The all-ones pattern shows whether the eighth bit leaks into a 7-bit entry. Parity is tried with correct and deliberately flipped parity bits under both even and odd settings, so a swapped sense or a stuck error flag each produce a wrong entry. A bad stop bit, a short glitch, a run of seventeen back-to-back characters and long quiet intervals separate the frame-error, false-start, overrun-drop and idle-timeout behaviours from the normal path.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int OS_RATE = 16;
    localparam int OS_W    = $clog2(OS_RATE);

    typedef struct packed {
        logic       frame_err;
        logic       par_err;
        logic [7:0] data;
    } rx_entry_t;

    localparam int ENTRY_W = $bits(rx_entry_t);

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_t;

    // Ticks in one character: start, data bits, optional parity, one stop.
    function automatic int unsigned char_ticks(input logic eight, input logic par_on);
        return OS_RATE * (2 + (eight ? 8 : 7) + (par_on ? 1 : 0));
    endfunction

endpackage

// File: rtl/srx_sampler.sv
module srx_sampler
    import srx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rxd,
    input  logic      cfg_eight,
    input  logic      cfg_par_en,
    input  logic      cfg_par_odd,
    output logic      done,
    output rx_entry_t word,
    output logic      busy
);
    localparam logic [OS_W-1:0] HALF_M1 = OS_W'(OS_RATE / 2 - 1);
    localparam logic [OS_W-1:0] FULL_M1 = OS_W'(OS_RATE - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   line;
    rx_state_t              state;
    logic [OS_W-1:0]        os_cnt;
    logic [2:0]             bit_idx;
    logic [7:0]             data_q;
    logic                   par_q, eight_q, pen_q, podd_q;
    logic [2:0]             last_idx;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
    end

    assign line     = sync_q[SYNC_STAGES-1];
    assign busy     = (state != RX_IDLE);
    assign last_idx = eight_q ? 3'd7 : 3'd6;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_IDLE;
            os_cnt  <= '0;
            bit_idx <= '0;
            data_q  <= '0;
            par_q   <= 1'b0;
            eight_q <= 1'b1;
            pen_q   <= 1'b0;
            podd_q  <= 1'b0;
            done    <= 1'b0;
            word    <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                unique case (state)
                    RX_IDLE: begin
                        if (!line) begin
                            state   <= RX_START;
                            os_cnt  <= '0;
                            bit_idx <= '0;
                            data_q  <= '0;
                            par_q   <= 1'b0;
                            eight_q <= cfg_eight;
                            pen_q   <= cfg_par_en;
                            podd_q  <= cfg_par_odd;
                        end
                    end
                    RX_START: begin
                        if (os_cnt == HALF_M1) begin
                            os_cnt <= '0;
                            state  <= line ? RX_IDLE : RX_DATA;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (os_cnt == FULL_M1) begin
                            os_cnt          <= '0;
                            data_q[bit_idx] <= line;
                            if (bit_idx == last_idx) state <= pen_q ? RX_PAR : RX_STOP;
                            else                     bit_idx <= bit_idx + 1'b1;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                    RX_PAR: begin
                        if (os_cnt == FULL_M1) begin
                            os_cnt <= '0;
                            par_q  <= line;
                            state  <= RX_STOP;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (os_cnt == FULL_M1) begin
                            os_cnt         <= '0;
                            done           <= 1'b1;
                            word.frame_err <= ~line;
                            word.par_err   <= pen_q & ((^data_q) ^ par_q ^ podd_q);
                            word.data      <= data_q;
                            state          <= RX_IDLE;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    AST_NARROW_MSB_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (done && !eight_q) |-> (word.data[7] == 1'b0)); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R2

endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 10
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          push,
    input  logic [WIDTH-1:0]              wdata,
    input  logic                          pop,
    output logic [WIDTH-1:0]              rdata,
    output logic [$clog2(DEPTH+1)-1:0]    count,
    output logic                          overrun
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign do_pop  = pop && (count != '0);
    assign do_push = push && ((count != FULL_CNT) || do_pop);
    assign overrun = push && !do_push;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT); // R8

    AST_OVERRUN_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (rst)
        overrun |=> (count == FULL_CNT)); // R9

    AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && count == '0) |=> (count == '0)); // R7

endmodule

// File: rtl/srx_idle_timer.sv
module srx_idle_timer
    import srx_pkg::*;
#(
    parameter int IDLE_CHARS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic busy,
    input  logic filled,
    input  logic cfg_eight,
    input  logic cfg_par_en,
    output logic expired
);
    localparam int MAX_TICKS = IDLE_CHARS * int'(char_ticks(1'b1, 1'b1));
    localparam int TW        = $clog2(MAX_TICKS + 1);

    logic [TW-1:0] cnt, limit;
    logic          fired;

    always_comb limit = TW'(IDLE_CHARS * int'(char_ticks(cfg_eight, cfg_par_en)));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            fired   <= 1'b0;
            expired <= 1'b0;
        end else begin
            expired <= 1'b0;
            if (busy || !filled) begin
                cnt   <= '0;
                fired <= 1'b0;
            end else if (tick && !fired) begin
                if (cnt == limit - 1'b1) begin
                    expired <= 1'b1;
                    fired   <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    AST_TIMEOUT_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
        expired |-> ($past(filled) && !$past(busy))); // R10

endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo
    import srx_pkg::*;
#(
    parameter int FIFO_DEPTH  = 16,
    parameter int ALMOST_FULL = 12,
    parameter int IDLE_CHARS  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            os_tick,
    input  logic                            rxd,
    input  logic                            cfg_eight_bits,
    input  logic                            cfg_par_en,
    input  logic                            cfg_par_odd,
    input  logic                            rd_pop,
    output logic [ENTRY_W-1:0]              rd_entry,
    output logic [$clog2(FIFO_DEPTH+1)-1:0] rd_level,
    output logic                            ev_almost_full,
    output logic                            ev_full,
    output logic                            ev_overrun,
    output logic                            ev_timeout
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    logic      char_done, rx_busy;
    rx_entry_t char_word;

    srx_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk         (clk),
        .rst         (rst),
        .tick        (os_tick),
        .rxd         (rxd),
        .cfg_eight   (cfg_eight_bits),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .done        (char_done),
        .word        (char_word),
        .busy        (rx_busy)
    );

    srx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(ENTRY_W)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .push    (char_done),
        .wdata   (char_word),
        .pop     (rd_pop),
        .rdata   (rd_entry),
        .count   (rd_level),
        .overrun (ev_overrun)
    );

    srx_idle_timer #(.IDLE_CHARS(IDLE_CHARS)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .tick       (os_tick),
        .busy       (rx_busy),
        .filled     (rd_level != '0),
        .cfg_eight  (cfg_eight_bits),
        .cfg_par_en (cfg_par_en),
        .expired    (ev_timeout)
    );

    assign ev_almost_full = (rd_level >= CW'(ALMOST_FULL));
    assign ev_full        = (rd_level == CW'(FIFO_DEPTH));

    AST_OVERRUN_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
        ev_overrun |-> ev_full); // R9

endmodule

// File: tb/sim_serial_rx_fifo.sv
module sim_serial_rx_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 2;

    logic clk = 1'b0, rst = 1'b1, os_tick = 1'b0, rxd = 1'b1;
    logic cfg8 = 1'b1, cpe = 1'b0, codd = 1'b0, pop = 1'b0;
    logic [9:0] entry;
    logic [4:0] level;
    logic af, full, ovr, tmo;

    int vectors = 0, errors = 0, ovr_seen = 0, tmo_seen = 0, tdiv = 0;
    logic [9:0] q[$];
    int exp_ovr = 0;

    serial_rx_fifo u0 (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd),
        .cfg_eight_bits(cfg8), .cfg_par_en(cpe), .cfg_par_odd(codd),
        .rd_pop(pop), .rd_entry(entry), .rd_level(level),
        .ev_almost_full(af), .ev_full(full), .ev_overrun(ovr), .ev_timeout(tmo)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        os_tick <= (tdiv == TICK_DIV - 1);
        tdiv    <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Per-clock monitor: event levels against the level, event pulse counting (R8)
    always @(negedge clk) begin
        if (!rst) begin
            check("R8 almost-full vs level", int'(af), int'(level >= 12));
            check("R8 full vs level", int'(full), int'(level == 16));
            if (ovr) ovr_seen++;
            if (tmo) tmo_seen++;
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    task automatic line_for(input logic v, input int ticks);
        rxd = v;
        repeat (ticks * TICK_DIV) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] data, input int nb, input logic pe,
                              input logic odd, input logic flip, input logic stop_ok);
        logic [7:0] d;
        logic p;
        d = (nb == 7) ? (data & 8'h7f) : data;
        p = (^d) ^ odd ^ flip;
        @(negedge clk);
        cfg8 = (nb == 8); cpe = pe; codd = odd;
        line_for(1'b0, 16);
        for (int i = 0; i < nb; i++) line_for(data[i], 16);
        if (pe) line_for(p, 16);
        if (stop_ok) line_for(1'b1, 16);
        else begin line_for(1'b0, 10); line_for(1'b1, 22); end
        if (q.size() < 16) q.push_back({~stop_ok, pe & flip, d});
        else exp_ovr++;
    endtask

    task automatic check_head(input string req);
        check({req, " level"}, int'(level), q.size());
        if (q.size() > 0) check({req, " entry"}, int'(entry), int'(q[0]));
    endtask

    task automatic pop_one(input string req);
        check_head(req);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        if (q.size() > 0) void'(q.pop_front());
        @(negedge clk);
        check({req, " after pop"}, int'(level), q.size());
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 level", int'(level), 0);
        check("R1 events", int'({af, full, ovr, tmo}), 0);
        rst = 1'b0;
        line_for(1'b1, 20);

        // R2: 8-bit characters, no parity
        send_frame(8'hA5, 8, 0, 0, 0, 1);
        check_head("R2 first");
        send_frame(8'h3C, 8, 0, 0, 0, 1);
        pop_one("R2/R7 order");
        pop_one("R7 second");
        // R7: pop on empty has no effect
        pop_one("R7 empty pop");
        send_frame(8'h01, 8, 0, 0, 0, 1);
        check_head("R7 after empty pop");
        pop_one("R7 drain");

        // R3: short glitch discarded
        line_for(1'b0, 3);
        line_for(1'b1, 40);
        check("R3 glitch level", int'(level), 0);

        // R4: 7-bit mode, bit 7 forced to zero
        send_frame(8'hFF, 7, 0, 0, 0, 1);
        check_head("R4 seven bit");
        pop_one("R4 drain");

        // R5: parity good and flipped, even and odd
        send_frame(8'h81, 8, 1, 0, 0, 1);
        send_frame(8'h81, 8, 1, 0, 1, 1);
        send_frame(8'h01, 8, 1, 1, 0, 1);
        send_frame(8'h6E, 7, 1, 1, 1, 1);
        pop_one("R5 even good");
        pop_one("R5 even bad");
        pop_one("R5 odd good");
        pop_one("R5 odd bad 7-bit");

        // R6: frame error, then R10 timeout while data waits
        send_frame(8'h55, 8, 0, 0, 0, 0);
        check_head("R6 frame error");
        tmo_seen = 0;
        line_for(1'b1, 500);
        check("R10 no early timeout", tmo_seen, 0);
        line_for(1'b1, 300);
        check("R10 timeout once", tmo_seen, 1);
        pop_one("R6 drain");
        tmo_seen = 0;
        line_for(1'b1, 800);
        check("R10 none when empty", tmo_seen, 0);

        // R8/R9: fill, thresholds, overrun
        ovr_seen = 0;
        exp_ovr = 0;
        for (int i = 0; i < 17; i++) begin
            send_frame(8'h10 + 8'(i), 8, 0, 0, 0, 1);
            if (i == 10) check("R8 almost-full off at 11", int'(af), 0);
            if (i == 11) check("R8 almost-full on at 12", int'({af, full}), 2);
            if (i == 15) check("R8 full at 16", int'(full), 1);
        end
        check("R9 overrun pulses", ovr_seen, exp_ovr);
        check("R9 overrun expected", exp_ovr, 1);
        check_head("R9 kept entries");
        for (int i = 0; i < 16; i++) pop_one("R9 drain order");
        check("R7 empty at end", int'(level), 0);

        finish_run();
    end
endmodule